// File: doc/BRIEF.md
# Index Register Arithmetic Unit

This block keeps a bank of eight 16-bit index registers and runs one register-level instruction per clock: add, subtract, load or compare. Each register has its own zero and carry status bits. A separate compare status holds only a zero bit and a carry bit. The second operand comes from one of three places:

- an 8-bit immediate, widened with zeros;
- a full 16-bit immediate;
- register R5, which is always the register operand and cannot be chosen.

The surrounding decoder presents the instruction fields together with a valid strobe. The result is written on that clock edge. A combinational read port lets the rest of the pipeline, or a test, see any register and its status bits.

A compare subtracts the operand from the destination register. The result goes only into the compare status. No register and no per-register status changes. Add, subtract and load write the destination register and refresh that register's own zero and carry bits.

Top module: `idx_arith_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every register, every per-register status bit and both compare status bits become 0.
- R2: `op_code` 00 (add) writes (dst + operand) mod 2^16 into the destination. The destination zero bit is set when that result is 0. Its carry bit is the carry out of bit 15.
- R3: `op_code` 01 (subtract) writes (dst − operand) mod 2^16. The zero bit is set when the result is 0. The carry bit is 1 when no borrow occurs (dst ≥ operand).
- R4: `op_code` 10 (load) writes the operand into the destination. The zero bit is set when the value is 0, and the carry bit is cleared.
- R5: `op_code` 11 (compare) sets `cmp_zf` when dst − operand is 0 and sets `cmp_cf` when dst ≥ operand. No register and no per-register status bit changes.
- R6: `src_sel` 00 takes `imm_val[7:0]` zero-extended to 16 bits as the operand. `imm_val[15:8]` is ignored.
- R7: `src_sel` 01 takes all 16 bits of `imm_val` as the operand.
- R8: `src_sel` 10 takes register R5 as the operand. When R5 is also the destination, its value from before the instruction is used.
- R9: `src_sel` 11 is reserved. An instruction with it changes no register and no status bit.
- R10: With `instr_vld` low, no register or status bit changes.
- R11: Add, subtract and load leave the compare status bits unchanged.
- R12: Each accepted instruction completes on its own clock edge. A back-to-back instruction on the next cycle sees the updated register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_vld | input | 1 | Instruction valid strobe |
| src_sel | input | 2 | Operand source: 00 imm8, 01 imm16, 10 R5, 11 reserved |
| op_code | input | 2 | 00 add, 01 subtract, 10 load, 11 compare |
| dst_idx | input | 3 | Destination register index |
| imm_val | input | 16 | Immediate value (low 8 bits used for imm8) |
| rd_sel | input | 3 | Read port register index |
| rd_data | output | 16 | Value of register `rd_sel` |
| rd_zf | output | 1 | Zero status bit of register `rd_sel` |
| rd_cf | output | 1 | Carry status bit of register `rd_sel` |
| cmp_zf | output | 1 | Compare zero bit |
| cmp_cf | output | 1 | Compare carry bit |

## Verification
The properties checked on every cycle are the ones about what must stay still:

- a compare, an idle cycle or a reserved source leaves the register bank untouched;
- only a compare moves the compare status bits;
- a load always clears carry;
- reset clears everything.

The arithmetic values cannot be shown by those properties. These are left to the bench's scenarios:

- wraparound of add;
- the borrow sense of subtract and compare;
- zero-extension of the short immediate;
- use of the old R5 when R5 is its own operand;
- forwarding between back-to-back instructions.

// File: rtl/idx_arith_pkg.sv
package idx_arith_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_MOV = 2'b10,
      OP_CMP = 2'b11
   } arith_op_e;

   typedef enum logic [1:0] {
      SRC_IMM_SHORT = 2'b00,
      SRC_IMM_FULL  = 2'b01,
      SRC_FIXED_REG = 2'b10,
      SRC_RESERVED  = 2'b11
   } operand_src_e;

endpackage

// File: rtl/idx_operand_sel.sv
module idx_operand_sel
   import idx_arith_pkg::*;
#(
   parameter int DW    = 16,
   parameter int IMM8W = 8
) (
   input  operand_src_e  src,
   input  logic [DW-1:0] imm_val,
   input  logic [DW-1:0] fixed_val,
   output logic [DW-1:0] operand,
   output logic          src_ok
);

   logic [DW-1:0] short_ext;

   // The short immediate is a positive constant: widen it with zeros.
   generate
      if (IMM8W == DW) begin : g_no_ext
         assign short_ext = imm_val;
      end else begin : g_zero_ext
         assign short_ext = {{(DW-IMM8W){1'b0}}, imm_val[IMM8W-1:0]};
      end
   endgenerate

   always_comb begin
      operand = '0;
      src_ok  = 1'b1;
      unique case (src)
         SRC_IMM_SHORT: operand = short_ext;
         SRC_IMM_FULL:  operand = imm_val;
         SRC_FIXED_REG: operand = fixed_val;
         default:       src_ok  = 1'b0;
      endcase
   end

endmodule

// File: rtl/idx_alu.sv
module idx_alu
   import idx_arith_pkg::*;
#(
   parameter int DW = 16
) (
   input  arith_op_e     op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] result,
   output logic          zf,
   output logic          cf,
   output logic          writes_reg
);

   logic [DW:0] sum_w;
   logic [DW:0] diff_w;

   assign sum_w  = {1'b0, a} + {1'b0, b};
   assign diff_w = {1'b0, a} - {1'b0, b};

   always_comb begin
      result     = '0;
      cf         = 1'b0;
      writes_reg = 1'b1;
      unique case (op)
         OP_ADD: begin
            result = sum_w[DW-1:0];
            cf     = sum_w[DW];
         end
         OP_SUB: begin
            result = diff_w[DW-1:0];
            cf     = ~diff_w[DW];
         end
         OP_MOV: begin
            result = b;
            cf     = 1'b0;
         end
         default: begin
            result     = diff_w[DW-1:0];
            cf         = ~diff_w[DW];
            writes_reg = 1'b0;
         end
      endcase
      zf = (result == '0);
   end

endmodule

// File: rtl/idx_regfile.sv
module idx_regfile #(
   parameter int DW        = 16,
   parameter int NREG      = 8,
   parameter int FIXED_IDX = 5,
   localparam int AW       = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [DW-1:0]    wdata,
   input  logic             wzf,
   input  logic             wcf,
   input  logic [AW-1:0]    dst_sel,
   input  logic [AW-1:0]    rd_sel,
   output logic [DW-1:0]    dst_data,
   output logic [DW-1:0]    fixed_data,
   output logic [DW-1:0]    rd_data,
   output logic             rd_zf,
   output logic             rd_cf,
   output logic [NREG*DW-1:0] regs_flat,
   output logic [NREG-1:0]  zf_flat,
   output logic [NREG-1:0]  cf_flat
);

   logic [DW-1:0] regs_q [NREG];
   logic [NREG-1:0] zf_q;
   logic [NREG-1:0] cf_q;

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               regs_q[i] <= '0;
               zf_q[i]   <= 1'b0;
               cf_q[i]   <= 1'b0;
            end else if (we && (waddr == AW'(i))) begin
               regs_q[i] <= wdata;
               zf_q[i]   <= wzf;
               cf_q[i]   <= wcf;
            end
         end
         assign regs_flat[i*DW +: DW] = regs_q[i];
      end
   endgenerate

   assign zf_flat    = zf_q;
   assign cf_flat    = cf_q;
   assign dst_data   = regs_q[dst_sel];
   assign fixed_data = regs_q[FIXED_IDX];
   assign rd_data    = regs_q[rd_sel];
   assign rd_zf      = zf_q[rd_sel];
   assign rd_cf      = cf_q[rd_sel];

endmodule

// File: rtl/idx_arith_unit.sv
module idx_arith_unit
   import idx_arith_pkg::*;
#(
   parameter int DW        = 16,
   parameter int IMM8W     = 8,
   parameter int NREG      = 8,
   parameter int FIXED_IDX = 5,
   localparam int AW       = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          instr_vld,
   input  logic [1:0]    src_sel,
   input  logic [1:0]    op_code,
   input  logic [AW-1:0] dst_idx,
   input  logic [DW-1:0] imm_val,
   input  logic [AW-1:0] rd_sel,
   output logic [DW-1:0] rd_data,
   output logic          rd_zf,
   output logic          rd_cf,
   output logic          cmp_zf,
   output logic          cmp_cf
);

   initial begin
      assert (IMM8W >= 1 && IMM8W <= DW)
         else $error("IMM8W must lie in 1..DW");
      assert (FIXED_IDX >= 0 && FIXED_IDX < NREG)
         else $error("FIXED_IDX must name an existing register");
      assert (NREG >= 2 && (1 << AW) == NREG)
         else $error("NREG must be a power of two, at least 2");
   end

   logic [DW-1:0]      dst_data;
   logic [DW-1:0]      fixed_data;
   logic [DW-1:0]      operand;
   logic               src_ok;
   logic [DW-1:0]      alu_res;
   logic               alu_zf;
   logic               alu_cf;
   logic               alu_writes;
   logic               do_exec;
   logic [NREG*DW-1:0] regs_flat;
   logic [NREG-1:0]    rzf_flat;
   logic [NREG-1:0]    rcf_flat;
   logic               cmp_zf_q;
   logic               cmp_cf_q;

   idx_operand_sel #(.DW(DW), .IMM8W(IMM8W)) opsel_i (
      .src       (operand_src_e'(src_sel)),
      .imm_val   (imm_val),
      .fixed_val (fixed_data),
      .operand   (operand),
      .src_ok    (src_ok)
   );

   idx_alu #(.DW(DW)) alu_i (
      .op         (arith_op_e'(op_code)),
      .a          (dst_data),
      .b          (operand),
      .result     (alu_res),
      .zf         (alu_zf),
      .cf         (alu_cf),
      .writes_reg (alu_writes)
   );

   assign do_exec = instr_vld && src_ok;

   idx_regfile #(.DW(DW), .NREG(NREG), .FIXED_IDX(FIXED_IDX)) rf_i (
      .clk        (clk),
      .rst        (rst),
      .we         (do_exec && alu_writes),
      .waddr      (dst_idx),
      .wdata      (alu_res),
      .wzf        (alu_zf),
      .wcf        (alu_cf),
      .dst_sel    (dst_idx),
      .rd_sel     (rd_sel),
      .dst_data   (dst_data),
      .fixed_data (fixed_data),
      .rd_data    (rd_data),
      .rd_zf      (rd_zf),
      .rd_cf      (rd_cf),
      .regs_flat  (regs_flat),
      .zf_flat    (rzf_flat),
      .cf_flat    (rcf_flat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cmp_zf_q <= 1'b0;
         cmp_cf_q <= 1'b0;
      end else if (do_exec && !alu_writes) begin
         cmp_zf_q <= alu_zf;
         cmp_cf_q <= alu_cf;
      end
   end

   assign cmp_zf = cmp_zf_q;
   assign cmp_cf = cmp_cf_q;

endmodule

// File: rtl/idx_arith_unit_chk.sv
module idx_arith_unit_chk #(
   parameter int DW   = 16,
   parameter int NREG = 8,
   localparam int AW  = $clog2(NREG)
) (
   input logic               clk,
   input logic               rst,
   input logic               instr_vld,
   input logic [1:0]         src_sel,
   input logic [1:0]         op_code,
   input logic [AW-1:0]      dst_idx,
   input logic [NREG*DW-1:0] regs_flat,
   input logic [NREG-1:0]    rzf_flat,
   input logic [NREG-1:0]    rcf_flat,
   input logic               cmp_zf,
   input logic               cmp_cf
);

   p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (regs_flat == '0 && rzf_flat == '0 && rcf_flat == '0 && !cmp_zf && !cmp_cf));

   p_move_clears_carry_r4: assert property (@(posedge clk) disable iff (rst)
      (instr_vld && op_code == 2'b10 && src_sel != 2'b11)
      |=> !rcf_flat[$past(dst_idx)]);

   p_compare_keeps_regs_r5: assert property (@(posedge clk) disable iff (rst)
      (instr_vld && op_code == 2'b11)
      |=> ($stable(regs_flat) && $stable(rzf_flat) && $stable(rcf_flat)));

   p_reserved_src_inert_r9: assert property (@(posedge clk) disable iff (rst)
      (instr_vld && src_sel == 2'b11)
      |=> ($stable(regs_flat) && $stable(rzf_flat) && $stable(rcf_flat)
           && $stable(cmp_zf) && $stable(cmp_cf)));

   p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
      !instr_vld
      |=> ($stable(regs_flat) && $stable(rzf_flat) && $stable(rcf_flat)
           && $stable(cmp_zf) && $stable(cmp_cf)));

   p_cmp_status_only_by_compare_r11: assert property (@(posedge clk) disable iff (rst)
      (instr_vld && op_code != 2'b11)
      |=> ($stable(cmp_zf) && $stable(cmp_cf)));

endmodule

bind idx_arith_unit idx_arith_unit_chk #(.DW(DW), .NREG(NREG)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .instr_vld (instr_vld),
   .src_sel   (src_sel),
   .op_code   (op_code),
   .dst_idx   (dst_idx),
   .regs_flat (regs_flat),
   .rzf_flat  (rzf_flat),
   .rcf_flat  (rcf_flat),
   .cmp_zf    (cmp_zf),
   .cmp_cf    (cmp_cf)
);

// File: tb/idx_arith_unit_tb.sv
`timescale 1ns/1ps
module idx_arith_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        instr_vld = 1'b0;
   logic [1:0]  src_sel = 2'b00;
   logic [1:0]  op_code = 2'b00;
   logic [2:0]  dst_idx = 3'd0;
   logic [15:0] imm_val = 16'h0;
   logic [2:0]  rd_sel = 3'd0;
   logic [15:0] rd_data;
   logic        rd_zf, rd_cf, cmp_zf, cmp_cf;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   idx_arith_unit dut_i (
      .clk(clk), .rst(rst), .instr_vld(instr_vld), .src_sel(src_sel),
      .op_code(op_code), .dst_idx(dst_idx), .imm_val(imm_val), .rd_sel(rd_sel),
      .rd_data(rd_data), .rd_zf(rd_zf), .rd_cf(rd_cf),
      .cmp_zf(cmp_zf), .cmp_cf(cmp_cf)
   );

   typedef struct packed {
      logic [1:0]  src;
      logic [1:0]  op;
      logic [2:0]  dst;
      logic [15:0] imm;
      logic [15:0] exp_d;
      logic        exp_z;
      logic        exp_c;
      logic        exp_cz;
      logic        exp_cc;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 2'd2, 3'd5, 16'h1234, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 load R5
      '{2'd1, 2'd2, 3'd1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
      '{2'd0, 2'd0, 3'd1, 16'hAB01, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 high byte ignored, R2 wrap
      '{2'd0, 2'd2, 3'd2, 16'h77F0, 16'h00F0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 zero-extend
      '{2'd1, 2'd1, 3'd2, 16'h00F0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 equal, no borrow
      '{2'd1, 2'd1, 3'd2, 16'h0001, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 borrow
      '{2'd2, 2'd0, 3'd2, 16'hDEAD, 16'h1233, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 carry, R8, R12
      '{2'd2, 2'd3, 3'd2, 16'h0000, 16'h1233, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 less than
      '{2'd1, 2'd3, 3'd2, 16'h1233, 16'h1233, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 equal
      '{2'd0, 2'd3, 3'd3, 16'hFF00, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 zero vs zero
      '{2'd2, 2'd0, 3'd5, 16'h0000, 16'h2468, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 self add, R11
      '{2'd2, 2'd1, 3'd5, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 self sub
      '{2'd3, 2'd2, 3'd4, 16'h5555, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 reserved source
      '{2'd1, 2'd2, 3'd5, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 clears carry
      '{2'd0, 2'd3, 3'd1, 16'h0005, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5}   // R5 borrow
   };

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state of every register
      for (int i = 0; i < 8; i++) begin
         rd_sel = 3'(i);
         #0.5;
         check("R1", "reg after reset", {rd_data[15:0]}, 16'h0);
         check("R1", "flags after reset", {14'b0, rd_zf, rd_cf}, 16'h0);
      end
      check("R1", "cmp after reset", {14'b0, cmp_zf, cmp_cf}, 16'h0);

      // Table walk, one instruction per cycle (R12 back-to-back)
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         instr_vld = 1'b1;
         src_sel   = VECS[v].src;
         op_code   = VECS[v].op;
         dst_idx   = VECS[v].dst;
         imm_val   = VECS[v].imm;
         rd_sel    = VECS[v].dst;
         @(posedge clk);
         #1;
         check($sformatf("R%0d", VECS[v].req), "data", rd_data, VECS[v].exp_d);
         check($sformatf("R%0d", VECS[v].req), "reg flags",
               {14'b0, rd_zf, rd_cf}, {14'b0, VECS[v].exp_z, VECS[v].exp_c});
         check($sformatf("R%0d", VECS[v].req), "cmp flags",
               {14'b0, cmp_zf, cmp_cf}, {14'b0, VECS[v].exp_cz, VECS[v].exp_cc});
      end

      // R10: strobe low with a load pending on the bus
      @(negedge clk);
      instr_vld = 1'b0;
      src_sel = 2'b01; op_code = 2'b10; dst_idx = 3'd2; imm_val = 16'hBEEF;
      rd_sel = 3'd2;
      repeat (2) @(posedge clk);
      #1;
      check("R10", "reg unchanged when idle", rd_data, 16'h1233);
      check("R10", "cmp unchanged when idle", {14'b0, cmp_zf, cmp_cf}, 16'h0);

      // R5: compare leaves R5 itself unchanged when it is also the operand
      @(negedge clk);
      instr_vld = 1'b1; src_sel = 2'b10; op_code = 2'b11; dst_idx = 3'd5; rd_sel = 3'd5;
      @(posedge clk);
      #1;
      check("R5", "R5 kept by compare", rd_data, 16'h0000);
      check("R5", "self compare flags", {14'b0, cmp_zf, cmp_cf}, 16'h3);

      // R1: mid-run reset clears everything again
      @(negedge clk);
      instr_vld = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      rd_sel = 3'd2;
      #0.5;
      check("R1", "reg after second reset", rd_data, 16'h0);
      check("R1", "cmp after second reset", {14'b0, cmp_zf, cmp_cf}, 16'h0);

      finish_run();
   end

endmodule